// File: doc/BRIEF.md
# Thread Interrupt Presenter Register Window

This block is the per-CPU register window of an interrupt presenter, for the operating-system privilege ring. Every CPU reaches its own copy at the same bus address. The window holds four bytes of state:

- a status byte, whose bit 7 flags a pending exception;
- the current priority of the processor;
- an eight-bit pending-priority bitmap;
- the priority of the best pending interrupt.

The block drives the interrupt line to the CPU.

A simple request bus reaches the window. Each request carries an address, an encoded byte size, write data and a write enable. One cycle later the block returns a response with read data and an error flag. Two kinds of address exist:

- **Ring addresses** `0x010`–`0x01F` are plain register accesses. The byte indices are: 0 status, 1 current priority, 2 pending bitmap, 3 best pending priority. Bytes 4 to 15 read as zero.
- **Operation addresses** are every address at or above `0x800`. A 2-byte read at `0x810` acknowledges the interrupt. A 1-byte write at `0x830` marks a priority as pending.

An upstream router, outside this block, raises the line. It pulses `notify_i` together with the priority it has chosen.

Top module: `irq_win_top`

## Requirements
- R1: A priority p maps to the bitmap bit `8'h80 >> p` when p < 8; any other priority maps to 0.
- R2: An acknowledge (read, size code 1, address `0x810`) with status bit 7 set does three things: it copies the best pending priority into the current priority, clears that priority's bitmap bit, and clears status bit 7. With bit 7 clear, it leaves the state unchanged.
- R3: An acknowledge always drops `irq_o`. It returns `{48'b0, status before the acknowledge, current priority after it}`.
- R4: Any write of the current-priority byte stores 8'hFF when the written value is above 7, and stores the value otherwise.
- R5: A request at an operation address that is neither a valid acknowledge nor a valid set-pending is rejected. The error flag is raised, reads return all ones, and no state changes.
- R6: A 1-byte write at `0x830` ORs the R1 encoding of the low data byte into the pending bitmap.
- R7: Ring reads of 1, 2, 4 or 8 bytes (size codes 0 to 3) that are naturally aligned return byte index+i in bits 8i and up, with zero above. A misaligned read is rejected with all-ones data.
- R8: The only writable ring byte is the current priority. A 1-byte write changes it only at index 1; writes at the other indices have no effect and no error. Aligned 4- and 8-byte writes update only that lane. A 2-byte write or a misaligned write is rejected with no change.
- R9: Any access below `0x800` and outside the ring is rejected: a write has no effect and a read returns all ones.
- R10: After reset the current priority is 8'hFF, the other bytes are zero, and `irq_o` is low.
- R11: A `notify_i` pulse loads the best pending priority, sets status bit 7 and raises `irq_o` at the next edge. It takes precedence over an acknowledge in the same cycle.
- R12: Each request gets exactly one response, with `rsp_valid_o` high in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Byte address in the window |
| req_size_i | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata_i | input | 64 | Write data; lane i is byte index+i |
| notify_i | input | 1 | Pending-interrupt notification pulse |
| notify_prio_i | input | 8 | Best pending priority delivered with the notification |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_rdata_o | output | 64 | Read data |
| rsp_err_o | output | 1 | Request was rejected |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
The assertions check several properties on every cycle:

- the one-to-one pairing of requests and responses;
- the all-ones data on rejected reads;
- the line rising after a notification and falling after an acknowledge;
- the line staying steady when neither event occurs.

Only the bench scenarios can show the following:

- the byte contents returned by an acknowledge;
- the clearing of the correct bitmap bit;
- the clamping of out-of-range priorities;
- that rejected and ignored writes leave every byte of state untouched, read back through the window.

// File: rtl/irq_win_pkg.sv
package irq_win_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 64;
    localparam int NUM_PRIO   = 8;
    localparam int RING_BYTES = 16;
    localparam int IDX_W      = $clog2(RING_BYTES);
    localparam int LANES      = DATA_W / 8;

    localparam logic [ADDR_W-1:0] OPS_BASE     = 16'h0800;
    localparam logic [ADDR_W-1:0] ACK_ADDR     = 16'h0810;
    localparam logic [ADDR_W-1:0] SETPEND_ADDR = 16'h0830;
    localparam logic [ADDR_W-1:0] RING_BASE    = 16'h0010;

    localparam logic [IDX_W-1:0] IDX_STAT = 4'd0;
    localparam logic [IDX_W-1:0] IDX_CUR  = 4'd1;
    localparam logic [IDX_W-1:0] IDX_PEND = 4'd2;
    localparam logic [IDX_W-1:0] IDX_BEST = 4'd3;
    localparam int EXC_BIT = 7;

    typedef enum logic [2:0] {
        OP_NONE, OP_RD, OP_WR, OP_ACK, OP_SETPEND, OP_REJ
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [IDX_W-1:0] idx;
        logic [1:0]       size;
    } dec_t;

    function automatic logic [7:0] prio_bit(input logic [7:0] p);
        return (int'(p) < NUM_PRIO) ? (8'h80 >> p) : 8'h00;
    endfunction

    function automatic logic [7:0] clamp_prio(input logic [7:0] p);
        return (int'(p) > NUM_PRIO - 1) ? 8'hFF : p;
    endfunction

    function automatic int size_bytes(input logic [1:0] s);
        return 1 << s;
    endfunction

endpackage

// File: rtl/irq_win_decode.sv
module irq_win_decode
    import irq_win_pkg::*;
(
    input  logic              valid_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output dec_t              dec_o
);
    logic [2:0] lo_mask;
    logic       aligned;
    logic       in_ring;

    always_comb begin
        lo_mask = 3'((size_bytes(size_i)) - 1);
        aligned = (addr_i[2:0] & lo_mask) == 3'd0;
        in_ring = addr_i[ADDR_W-1:IDX_W] == RING_BASE[ADDR_W-1:IDX_W];

        dec_o.idx  = addr_i[IDX_W-1:0];
        dec_o.size = size_i;
        dec_o.op   = OP_NONE;
        if (valid_i) begin
            if (addr_i >= OPS_BASE) begin
                if (!we_i && addr_i == ACK_ADDR && size_i == 2'd1)
                    dec_o.op = OP_ACK;
                else if (we_i && addr_i == SETPEND_ADDR && size_i == 2'd0)
                    dec_o.op = OP_SETPEND;
                else
                    dec_o.op = OP_REJ;
            end else if (in_ring) begin
                if (!we_i)
                    dec_o.op = aligned ? OP_RD : OP_REJ;
                else if (size_i == 2'd0 || (size_i[1] && aligned))
                    dec_o.op = OP_WR;
                else
                    dec_o.op = OP_REJ;
            end else begin
                dec_o.op = OP_REJ;
            end
        end
    end
endmodule

// File: rtl/irq_win_state.sv
module irq_win_state
    import irq_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              notify_i,
    input  logic [7:0]        notify_prio_i,
    output logic [7:0]        stat_o,
    output logic [7:0]        cur_o,
    output logic [7:0]        pend_o,
    output logic [7:0]        best_o,
    output logic              irq_o,
    output logic [15:0]       ack_word_o
);
    logic [7:0] stat_n, cur_n, pend_n, best_n;
    logic       irq_n;
    logic [IDX_W-1:0] lane;
    logic       hits_cur;

    always_comb begin
        stat_n = stat_o;
        cur_n  = cur_o;
        pend_n = pend_o;
        best_n = best_o;
        irq_n  = irq_o;
        lane     = IDX_CUR - dec_i.idx;
        hits_cur = (dec_i.idx <= IDX_CUR) && (int'(lane) < size_bytes(dec_i.size));

        unique case (dec_i.op)
            OP_WR: begin
                if (dec_i.size == 2'd0) begin
                    if (dec_i.idx == IDX_CUR) cur_n = clamp_prio(wdata_i[7:0]);
                end else if (hits_cur) begin
                    cur_n = clamp_prio(wdata_i[8*lane +: 8]);
                end
            end
            OP_SETPEND: pend_n = pend_o | prio_bit(wdata_i[7:0]);
            OP_ACK: begin
                irq_n = 1'b0;
                if (stat_o[EXC_BIT]) begin
                    cur_n           = best_o;
                    pend_n          = pend_o & ~prio_bit(best_o);
                    stat_n[EXC_BIT] = 1'b0;
                end
            end
            default: ;
        endcase

        if (notify_i) begin
            best_n          = notify_prio_i;
            stat_n[EXC_BIT] = 1'b1;
            irq_n           = 1'b1;
        end
        ack_word_o = {stat_o, (stat_o[EXC_BIT] ? best_o : cur_o)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_o <= 8'h00;
            cur_o  <= 8'hFF;
            pend_o <= 8'h00;
            best_o <= 8'h00;
            irq_o  <= 1'b0;
        end else begin
            stat_o <= stat_n;
            cur_o  <= cur_n;
            pend_o <= pend_n;
            best_o <= best_n;
            irq_o  <= irq_n;
        end
    end
endmodule

// File: rtl/irq_win_top.sv
module irq_win_top
    import irq_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic              req_we_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_size_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              notify_i,
    input  logic [7:0]        notify_prio_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              rsp_err_o,
    output logic              irq_o
);
    dec_t        dec;
    logic [7:0]  stat, cur, pend, best;
    logic [15:0] ack_word;
    logic [DATA_W-1:0] ring_data, rdata_n;

    irq_win_decode u_dec (
        .valid_i (req_valid_i),
        .we_i    (req_we_i),
        .addr_i  (req_addr_i),
        .size_i  (req_size_i),
        .dec_o   (dec)
    );

    irq_win_state u_state (
        .clk           (clk),
        .rst           (rst),
        .dec_i         (dec),
        .wdata_i       (req_wdata_i),
        .notify_i      (notify_i),
        .notify_prio_i (notify_prio_i),
        .stat_o        (stat),
        .cur_o         (cur),
        .pend_o        (pend),
        .best_o        (best),
        .irq_o         (irq_o),
        .ack_word_o    (ack_word)
    );

    always_comb begin
        ring_data = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [IDX_W-1:0] k;
            logic [7:0]       b;
            k = dec.idx + IDX_W'(i);
            unique case (k)
                IDX_STAT: b = stat;
                IDX_CUR:  b = cur;
                IDX_PEND: b = pend;
                IDX_BEST: b = best;
                default:  b = 8'h00;
            endcase
            if (i < size_bytes(dec.size)) ring_data[8*i +: 8] = b;
        end

        unique case (dec.op)
            OP_RD:   rdata_n = ring_data;
            OP_ACK:  rdata_n = {{(DATA_W-16){1'b0}}, ack_word};
            OP_REJ:  rdata_n = req_we_i ? '0 : '1;
            default: rdata_n = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_err_o   <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= req_valid_i;
            rsp_err_o   <= dec.op == OP_REJ;
            rsp_rdata_o <= rdata_n;
        end
    end
endmodule

// File: rtl/irq_win_chk.sv
module irq_win_chk
    import irq_win_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid_i,
    input logic              req_we_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic [1:0]        req_size_i,
    input logic              notify_i,
    input logic              rsp_valid_o,
    input logic [DATA_W-1:0] rsp_rdata_o,
    input logic              rsp_err_o,
    input logic              irq_o
);
    logic is_ack;
    assign is_ack = req_valid_i && !req_we_i && req_addr_i == ACK_ADDR && req_size_i == 2'd1;

    // R12
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> rsp_valid_o);

    // R12
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> !rsp_valid_o);

    // R5
    rejected_read_ones_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid_i && !req_we_i && req_addr_i >= OPS_BASE && !is_ack |=>
            rsp_err_o && (&rsp_rdata_o));

    // R3
    ack_drops_line_chk: assert property (@(posedge clk) disable iff (rst)
        is_ack && !notify_i |=> !irq_o);

    // R11
    notify_raises_chk: assert property (@(posedge clk) disable iff (rst)
        notify_i |=> irq_o);

    // R11
    line_steady_chk: assert property (@(posedge clk) disable iff (rst)
        !notify_i && !is_ack |=> $stable(irq_o));
endmodule

bind irq_win_top irq_win_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_addr_i  (req_addr_i),
    .req_size_i  (req_size_i),
    .notify_i    (notify_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_err_o   (rsp_err_o),
    .irq_o       (irq_o)
);

// File: tb/irq_win_top_tb.sv
`timescale 1ns/1ps
module irq_win_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0;
    logic        req_we_i = 1'b0;
    logic [15:0] req_addr_i = '0;
    logic [1:0]  req_size_i = '0;
    logic [63:0] req_wdata_i = '0;
    logic        notify_i = 1'b0;
    logic [7:0]  notify_prio_i = '0;
    logic        rsp_valid_o;
    logic [63:0] rsp_rdata_o;
    logic        rsp_err_o;
    logic        irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    localparam logic [15:0] RING = 16'h0010;
    localparam logic [15:0] ACK  = 16'h0810;
    localparam logic [15:0] SETP = 16'h0830;
    localparam logic [63:0] ONES = '1;

    always #4 clk = ~clk;

    irq_win_top u_dut (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [15:0] a, input logic [1:0] sz,
                          input logic [63:0] wd, input bit exp_err,
                          input logic [63:0] exp_rd, input string tag);
        @(negedge clk);
        req_valid_i = 1'b1; req_we_i = we; req_addr_i = a;
        req_size_i = sz; req_wdata_i = wd;
        @(negedge clk);
        req_valid_i = 1'b0;
        check(rsp_valid_o == 1'b1, {tag, " R12 rsp_valid"}, 64'(rsp_valid_o), 64'd1);
        check(rsp_err_o == exp_err, {tag, " err"}, 64'(rsp_err_o), 64'(exp_err));
        if (!we) check(rsp_rdata_o == exp_rd, {tag, " rdata"}, rsp_rdata_o, exp_rd);
    endtask

    task automatic notify(input logic [7:0] p);
        @(negedge clk);
        notify_i = 1'b1; notify_prio_i = p;
        @(negedge clk);
        notify_i = 1'b0;
    endtask

    task automatic t_reset;
        check(irq_o == 1'b0, "R10 irq after reset", 64'(irq_o), 0);
        access(0, RING, 2'd3, 0, 0, 64'h0000_0000_0000_FF00, "R10 reset bytes");
        @(negedge clk);
        check(rsp_valid_o == 1'b0, "R12 idle no rsp", 64'(rsp_valid_o), 0);
    endtask

    task automatic t_cur_prio;
        access(1, RING + 1, 2'd0, 64'h05, 0, 0, "R4 wr 5");
        access(0, RING + 1, 2'd0, 0, 0, 64'h05, "R4 rd 5");
        access(1, RING + 1, 2'd0, 64'h09, 0, 0, "R4 wr 9");
        access(0, RING + 1, 2'd0, 0, 0, 64'hFF, "R4 clamp");
        access(1, RING, 2'd0, 64'h07, 0, 0, "R8 wr idx0 ignored");
        access(0, RING, 2'd3, 0, 0, 64'hFF00, "R8 idx0 unchanged");
    endtask

    task automatic t_setpend;
        access(1, SETP, 2'd0, 64'h02, 0, 0, "R6 set 2");
        access(0, RING + 2, 2'd0, 0, 0, 64'h20, "R1 bit for 2");
        access(1, SETP, 2'd0, 64'h00, 0, 0, "R6 set 0");
        access(0, RING + 2, 2'd0, 0, 0, 64'hA0, "R6 or-in");
        access(1, SETP, 2'd0, 64'h09, 0, 0, "R1 set 9");
        access(0, RING + 2, 2'd0, 0, 0, 64'hA0, "R1 out of range");
        access(1, SETP, 2'd1, 64'h03, 1, 0, "R5 setpend size2");
        access(0, RING + 2, 2'd0, 0, 0, 64'hA0, "R5 no change");
    endtask

    task automatic t_ack;
        notify(8'd2);
        check(irq_o == 1'b1, "R11 irq raised", 64'(irq_o), 1);
        access(0, RING, 2'd3, 0, 0, 64'h02A0_FF80, "R11 state");
        access(0, ACK, 2'd0, 0, 1, ONES, "R5 ack size1");
        check(irq_o == 1'b1, "R5 irq kept", 64'(irq_o), 1);
        access(0, ACK, 2'd1, 0, 0, 64'h8002, "R3 ack word");
        check(irq_o == 1'b0, "R3 irq dropped", 64'(irq_o), 0);
        access(0, RING, 2'd2, 0, 0, 64'h0280_0200, "R2 after ack");
        access(0, ACK, 2'd1, 0, 0, 64'h0002, "R3 ack no exc");
        access(0, RING, 2'd2, 0, 0, 64'h0280_0200, "R2 no exc unchanged");
        access(0, 16'h0800, 2'd1, 0, 1, ONES, "R5 base op");
    endtask

    task automatic t_plain;
        access(0, RING + 1, 2'd1, 0, 1, ONES, "R7 misaligned");
        access(0, RING + 2, 2'd1, 0, 0, 64'h0280, "R7 two bytes");
        access(1, RING, 2'd2, 64'h1122_0344, 0, 0, "R8 wide wr");
        access(0, RING, 2'd2, 0, 0, 64'h0280_0300, "R8 lane only");
        access(1, RING + 8, 2'd3, 64'h0C00, 0, 0, "R8 8B wr off-lane");
        access(0, RING, 2'd2, 0, 0, 64'h0280_0300, "R8 off-lane no change");
        access(1, RING, 2'd3, 64'h0C00, 0, 0, "R4 8B clamp wr");
        access(0, RING, 2'd2, 0, 0, 64'h0280_FF00, "R4 8B clamp");
        access(1, RING, 2'd1, 64'h0500, 1, 0, "R8 size2 wr");
        access(1, RING + 2, 2'd2, 64'h0500, 1, 0, "R8 misaligned wr");
        access(0, RING, 2'd2, 0, 0, 64'h0280_FF00, "R8 rejected no change");
    endtask

    task automatic t_outside;
        access(0, 16'h0100, 2'd0, 0, 1, ONES, "R9 outside rd");
        access(1, 16'h0101, 2'd0, 64'h03, 1, 0, "R9 outside wr");
        access(0, RING, 2'd3, 0, 0, 64'h0280_FF00, "R9 no change");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cur_prio();
        t_setpend();
        t_ack();
        t_plain();
        t_outside();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule